// File: doc/BRIEF.md
# Internal Data RAM Access Decoder

This block sits in front of a 128-byte on-chip data RAM and turns three styles of operand reference into RAM accesses. A register operand gives a register number from 0 to 7 and a two-bit bank select, and lands in one of four groups of eight bytes at the bottom of the RAM. A direct operand gives an 8-bit byte address. Its lower half reaches the RAM and its upper half belongs to the special-function-register side. A bit operand gives an 8-bit bit address. Its lower half selects one bit inside the sixteen-byte window at 20H to 2FH, and its upper half is again handed to the special-function-register side.

The decode of the request currently presented is always visible on plain status outputs: the RAM byte address, the bit index, the special-function-register flag and a region code. Requests enter through a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Reads return one beat on a valid/ready response channel. While a response is waiting, `req_ready` stays low and the response fields hold steady until `rsp_ready` takes the beat. Writes return no beat.

A bit write is a read-modify-write. In the cycle the request is taken, the byte is read. In the next cycle it is written back with only the chosen bit replaced. `busy` marks that second cycle. Register bytes have no bit addresses, so changing one bit of a register takes a full byte write.

Top module: `iram_bank_bit_decoder`

## Requirements
- R1: With `req_kind` = 2'b00 (register), `dec_addr` equals bank × 8 + register number, and `dec_sfr` is 0.
- R2: With `req_kind` = 2'b01 (direct), an address below 80H gives `dec_addr` = address[6:0] and `dec_sfr` = 0. An address of 80H or above gives `dec_sfr` = 1.
- R3: With `req_kind` = 2'b10 (bit), an address below 80H gives `dec_addr` = 20H + address[6:3] and `dec_bit` = address[2:0]. An address of 80H or above gives `dec_sfr` = 1. A bit access never writes a byte outside 20H–2FH.
- R4: `dec_region` is 0 for RAM bytes 00H–1FH, 1 for 20H–2FH, 2 for 30H–7FH, and 3 whenever `dec_sfr` is 1.
- R5: A read taken at edge k raises `rsp_valid` in the cycle after k. `rsp_data` then carries the stored byte, `rsp_bit` carries its bit `dec_bit`, and `rsp_sfr` is 0.
- R6: A byte write (register or direct) is stored at the edge where it is taken. It produces no response, and `req_ready` and `busy` stay high and low respectively in the next cycle.
- R7: A bit write changes only the chosen bit of its byte. `busy` is high, and `req_ready` low, for exactly the one cycle after acceptance.
- R8: A special-function-register access neither reads nor writes the RAM. A read of that kind returns a beat with `rsp_sfr` = 1 and `rsp_data` = 0. A write of that kind leaves every RAM byte unchanged.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and `req_ready` stays low.
- R10: After reset, `req_ready` = 1, `busy` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 00 register, 01 direct, 10 bit, 11 handled as direct |
| req_bank | input | 2 | Register bank select |
| req_reg | input | 3 | Register number within the bank |
| req_addr | input | 8 | Direct byte address or bit address |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Byte write data |
| req_wbit | input | 1 | Bit write value |
| dec_addr | output | 7 | Decoded RAM byte address of the presented request |
| dec_bit | output | 3 | Decoded bit index (0 for byte kinds) |
| dec_sfr | output | 1 | Presented request targets the special-function-register side |
| dec_region | output | 2 | Region code of the presented request |
| busy | output | 1 | Bit-write merge cycle in progress |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_data | output | 8 | Read byte |
| rsp_bit | output | 1 | Selected bit of the read byte |
| rsp_sfr | output | 1 | Response belongs to a special-function-register read |

## Verification
The bench targets the edges of each map. These are bank 3 register 7 (byte 1FH), bit addresses 00H and 7FH (bytes 20H and 2FH), and direct and bit addresses just above 7FH. A decoder that drops the bank shift, or shifts the bit address the wrong way, would read or write a byte other than the one the bench model expects. A bench-side image of the RAM is read back byte by byte at the end. A merge that cleared neighbouring bits, or an SFR write that leaked into RAM byte address[6:0], would show up as a mismatch there. Reads with the response held back for several cycles expose a design that lets the data drift or that accepts a new request over a pending beat.

// File: rtl/iram_pkg.sv
package iram_pkg;

  typedef enum logic [1:0] {
    ACC_REG    = 2'b00,
    ACC_DIRECT = 2'b01,
    ACC_BIT    = 2'b10,
    ACC_RSVD   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    RGN_BANKS   = 2'd0,
    RGN_BITWIN  = 2'd1,
    RGN_SCRATCH = 2'd2,
    RGN_SFR     = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RESP  = 2'd1,
    SQ_MERGE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int RAM_BYTES       = 128,
  parameter int BANK_COUNT      = 4,
  parameter int BANK_REGS       = 8,
  parameter int DATA_W          = 8,
  parameter int BIT_WINDOW_BASE = 32,
  parameter int SCRATCH_BASE    = 48
) (
  input  logic [1:0]                      kind,
  input  logic [$clog2(BANK_COUNT)-1:0]   bank,
  input  logic [$clog2(BANK_REGS)-1:0]    regn,
  input  logic [ADDR_W-1:0]               addr,
  output logic [$clog2(RAM_BYTES)-1:0]    byte_addr,
  output logic [$clog2(DATA_W)-1:0]       bit_idx,
  output logic                            is_sfr,
  output logic [1:0]                      region
);
  localparam int RAM_AW    = $clog2(RAM_BYTES);
  localparam int BIT_IDX_W = $clog2(DATA_W);
  localparam logic [RAM_AW-1:0] WIN_LO  = RAM_AW'(BIT_WINDOW_BASE);
  localparam logic [RAM_AW-1:0] SCR_LO  = RAM_AW'(SCRATCH_BASE);
  localparam logic [RAM_AW-1:0] BANK_SZ = RAM_AW'(BANK_REGS);

  acc_kind_e kind_e;
  assign kind_e = acc_kind_e'(kind);

  always_comb begin
    byte_addr = addr[RAM_AW-1:0];
    bit_idx   = '0;
    is_sfr    = 1'b0;
    unique case (kind_e)
      ACC_REG: begin
        byte_addr = RAM_AW'(bank) * BANK_SZ + RAM_AW'(regn);
      end
      ACC_BIT: begin
        is_sfr    = addr[ADDR_W-1];
        byte_addr = WIN_LO + RAM_AW'(addr[ADDR_W-2:BIT_IDX_W]);
        bit_idx   = addr[BIT_IDX_W-1:0];
      end
      default: begin
        is_sfr    = addr[ADDR_W-1];
        byte_addr = addr[RAM_AW-1:0];
      end
    endcase
  end

  always_comb begin
    if (is_sfr)                 region = RGN_SFR;
    else if (byte_addr < WIN_LO) region = RGN_BANKS;
    else if (byte_addr < SCR_LO) region = RGN_BITWIN;
    else                        region = RGN_SCRATCH;
  end

endmodule

// File: rtl/iram_sync_ram.sv
module iram_sync_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     re,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/iram_access_seq.sv
module iram_access_seq
  import iram_pkg::*;
#(
  parameter int RAM_BYTES = 128,
  parameter int DATA_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic                         kind_is_bit,
  input  logic [$clog2(RAM_BYTES)-1:0] dec_addr,
  input  logic [$clog2(DATA_W)-1:0]    dec_bit,
  input  logic                         dec_sfr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         wbit,
  output logic                         busy,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DATA_W-1:0]            rsp_data,
  output logic                         rsp_bit,
  output logic                         rsp_sfr,
  output logic                         ram_re,
  output logic                         ram_we,
  output logic [$clog2(RAM_BYTES)-1:0] ram_addr,
  output logic [DATA_W-1:0]            ram_wdata,
  input  logic [DATA_W-1:0]            ram_rdata
);
  localparam int RAM_AW    = $clog2(RAM_BYTES);
  localparam int BIT_IDX_W = $clog2(DATA_W);

  seq_state_e             state, state_nx;
  logic [RAM_AW-1:0]      addr_q;
  logic [BIT_IDX_W-1:0]   bit_q;
  logic                   wbit_q;
  logic                   sfr_q;
  logic                   accept;
  logic [DATA_W-1:0]      merged;

  assign req_ready = (state == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (state == SQ_MERGE);
  assign rsp_valid = (state == SQ_RESP);
  assign rsp_sfr   = sfr_q;
  assign rsp_data  = sfr_q ? '0 : ram_rdata;
  assign rsp_bit   = sfr_q ? 1'b0 : ram_rdata[bit_q];

  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    assign merged[i] = (bit_q == BIT_IDX_W'(i)) ? wbit_q : ram_rdata[i];
  end

  always_comb begin
    state_nx  = state;
    ram_re    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = dec_addr;
    ram_wdata = wdata;
    unique case (state)
      SQ_IDLE: begin
        if (accept) begin
          if (dec_sfr) begin
            if (!req_write) state_nx = SQ_RESP;
          end else if (!req_write) begin
            ram_re   = 1'b1;
            state_nx = SQ_RESP;
          end else if (kind_is_bit) begin
            ram_re   = 1'b1;
            state_nx = SQ_MERGE;
          end else begin
            ram_we = 1'b1;
          end
        end
      end
      SQ_RESP: begin
        ram_addr = addr_q;
        if (rsp_ready) state_nx = SQ_IDLE;
      end
      SQ_MERGE: begin
        ram_addr  = addr_q;
        ram_wdata = merged;
        ram_we    = 1'b1;
        state_nx  = SQ_IDLE;
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      addr_q <= '0;
      bit_q  <= '0;
      wbit_q <= 1'b0;
      sfr_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        addr_q <= dec_addr;
        bit_q  <= dec_bit;
        wbit_q <= wbit;
        sfr_q  <= dec_sfr;
      end
    end
  end

endmodule

// File: rtl/iram_bank_bit_decoder.sv
module iram_bank_bit_decoder
  import iram_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int RAM_BYTES       = 128,
  parameter int BANK_COUNT      = 4,
  parameter int BANK_REGS       = 8,
  parameter int DATA_W          = 8,
  parameter int BIT_WINDOW_BASE = 32,
  parameter int SCRATCH_BASE    = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_kind,
  input  logic [$clog2(BANK_COUNT)-1:0] req_bank,
  input  logic [$clog2(BANK_REGS)-1:0]  req_reg,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_write,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic                          req_wbit,
  output logic [$clog2(RAM_BYTES)-1:0]  dec_addr,
  output logic [$clog2(DATA_W)-1:0]     dec_bit,
  output logic                          dec_sfr,
  output logic [1:0]                    dec_region,
  output logic                          busy,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          rsp_bit,
  output logic                          rsp_sfr
);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  logic              ram_re;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;
  logic              kind_is_bit;

  assign kind_is_bit = (acc_kind_e'(req_kind) == ACC_BIT);

  iram_addr_map #(
    .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .BANK_COUNT(BANK_COUNT),
    .BANK_REGS(BANK_REGS), .DATA_W(DATA_W),
    .BIT_WINDOW_BASE(BIT_WINDOW_BASE), .SCRATCH_BASE(SCRATCH_BASE)
  ) u_map (
    .kind      (req_kind),
    .bank      (req_bank),
    .regn      (req_reg),
    .addr      (req_addr),
    .byte_addr (dec_addr),
    .bit_idx   (dec_bit),
    .is_sfr    (dec_sfr),
    .region    (dec_region)
  );

  iram_access_seq #(
    .RAM_BYTES(RAM_BYTES), .DATA_W(DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .kind_is_bit (kind_is_bit),
    .dec_addr    (dec_addr),
    .dec_bit     (dec_bit),
    .dec_sfr     (dec_sfr),
    .wdata       (req_wdata),
    .wbit        (req_wbit),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .rsp_bit     (rsp_bit),
    .rsp_sfr     (rsp_sfr),
    .ram_re      (ram_re),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .ram_rdata   (ram_rdata)
  );

  iram_sync_ram #(
    .DEPTH(RAM_BYTES), .WIDTH(DATA_W)
  ) u_ram (
    .clk   (clk),
    .re    (ram_re),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/iram_checker.sv
module iram_checker #(
  parameter int RAM_AW = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              dec_sfr,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              ram_re,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);
  localparam logic [RAM_AW-1:0] WIN_FIRST = RAM_AW'(32);
  localparam logic [RAM_AW-1:0] WIN_LAST  = RAM_AW'(47);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid); // R5

  AST_MERGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R7

  AST_MERGE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R7

  AST_MERGE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ram_we |-> (ram_addr >= WIN_FIRST && ram_addr <= WIN_LAST)); // R3

  AST_SFR_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && dec_sfr |-> !ram_we && !ram_re); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && !req_ready); // R9

endmodule

bind iram_bank_bit_decoder iram_checker #(
  .RAM_AW($clog2(RAM_BYTES)), .DATA_W(DATA_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .dec_sfr   (dec_sfr),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ram_re    (ram_re),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr)
);

// File: tb/iram_bank_bit_decoder_bench.sv
`timescale 1ns/1ps
module iram_bank_bit_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'b00;
  logic [1:0] req_bank = 2'b00;
  logic [2:0] req_reg = 3'd0;
  logic [7:0] req_addr = 8'd0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = 8'd0;
  logic       req_wbit = 1'b0;
  logic [6:0] dec_addr;
  logic [2:0] dec_bit;
  logic       dec_sfr;
  logic [1:0] dec_region;
  logic       busy;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic       rsp_bit;
  logic       rsp_sfr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  iram_bank_bit_decoder u_iram_bank_bit_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_bank(req_bank), .req_reg(req_reg),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_wbit(req_wbit), .dec_addr(dec_addr), .dec_bit(dec_bit),
    .dec_sfr(dec_sfr), .dec_region(dec_region), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_bit(rsp_bit), .rsp_sfr(rsp_sfr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_sfr(input logic [1:0] k, input logic [7:0] a);
    return (k != 2'b00) && a[7];
  endfunction

  function automatic logic [6:0] exp_addr(input logic [1:0] k, input logic [1:0] b,
                                          input logic [2:0] r, input logic [7:0] a);
    if (k == 2'b00) return 7'(b * 8 + r);
    if (k == 2'b10) return 7'(32 + (a[6:0] >> 3));
    return a[6:0];
  endfunction

  function automatic logic [1:0] exp_region(input bit s, input logic [6:0] ba);
    if (s) return 2'd3;
    if (ba < 7'h20) return 2'd0;
    if (ba < 7'h30) return 2'd1;
    return 2'd2;
  endfunction

  // One complete access, started and ended on a falling edge.
  task automatic do_op(input logic [1:0] k, input logic [1:0] b, input logic [2:0] r,
                       input logic [7:0] a, input bit wr, input logic [7:0] wd,
                       input bit wb, input int stall);
    bit         s;
    logic [6:0] ea;
    logic [2:0] eb;
    logic [7:0] held;
    s  = exp_sfr(k, a);
    ea = exp_addr(k, b, r, a);
    eb = (k == 2'b10) ? a[2:0] : 3'd0;
    req_kind = k; req_bank = b; req_reg = r; req_addr = a;
    req_write = wr; req_wdata = wd; req_wbit = wb; req_valid = 1'b1;
    #0.1;
    while (!req_ready) begin @(negedge clk); #0.1; end
    chk(dec_sfr == s, (k == 2'b10) ? "R3 sfr flag" : "R2 sfr flag", dec_sfr, s);
    if (!s) begin
      chk(dec_addr == ea, (k == 2'b00) ? "R1 reg addr" :
                          (k == 2'b10) ? "R3 bit byte" : "R2 direct addr", dec_addr, ea);
      if (k == 2'b10) chk(dec_bit == eb, "R3 bit index", dec_bit, eb);
    end
    chk(dec_region == exp_region(s, ea), "R4 region", dec_region, exp_region(s, ea));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      chk(rsp_valid == 1'b1, "R5 rsp_valid", rsp_valid, 1);
      if (s) begin
        chk(rsp_sfr == 1'b1 && rsp_data == 8'h00, "R8 sfr read beat", rsp_data, 0);
      end else begin
        chk(rsp_sfr == 1'b0, "R5 rsp_sfr", rsp_sfr, 0);
        chk(rsp_data == model[ea], "R5 read data", rsp_data, model[ea]);
        if (k == 2'b10) chk(rsp_bit == model[ea][eb], "R5 read bit", rsp_bit, model[ea][eb]);
      end
      held = rsp_data;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == held && !req_ready, "R9 held beat", rsp_data, held);
      end
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 beat released", rsp_valid, 0);
    end else if (s) begin
      chk(!rsp_valid && !busy && req_ready, "R8 sfr write quiet", {rsp_valid, busy}, 0);
    end else if (k != 2'b10) begin
      model[ea] = wd;
      chk(req_ready && !busy && !rsp_valid, "R6 byte write no stall",
          {req_ready, busy, rsp_valid}, 3'b100);
    end else begin
      model[ea][eb] = wb;
      chk(busy && !req_ready, "R7 merge cycle", {busy, req_ready}, 2'b10);
      @(negedge clk);
      chk(!busy && req_ready, "R7 merge ends", {busy, req_ready}, 2'b01);
    end
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 128; i++) begin
      do_op(2'b01, 2'b00, 3'd0, 8'(i), 1'b0, 8'h00, 1'b0, 0);
    end
    $display("sweep done: %s", tag);
  endtask

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0 && rsp_valid == 1'b0, "R10 reset state",
        {req_ready, busy, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0 && rsp_valid == 1'b0, "R10 after release",
        {req_ready, busy, rsp_valid}, 3'b100);

    for (int i = 0; i < 128; i++) begin
      do_op(2'b01, 2'b00, 3'd0, 8'(i), 1'b1, 8'($urandom), 1'b0, 0);
    end

    // R1 corners: bank 1 reg 7 lands at 0FH, bank 3 reg 7 at 1FH
    do_op(2'b00, 2'd1, 3'd7, 8'h00, 1'b1, 8'hA5, 1'b0, 0);
    do_op(2'b01, 2'd0, 3'd0, 8'h0F, 1'b0, 8'h00, 1'b0, 0);
    do_op(2'b00, 2'd3, 3'd7, 8'h00, 1'b1, 8'h3C, 1'b0, 0);
    do_op(2'b01, 2'd0, 3'd0, 8'h1F, 1'b0, 8'h00, 1'b0, 1);
    do_op(2'b00, 2'd0, 3'd0, 8'hFF, 1'b0, 8'h00, 1'b0, 0);
    // R3 corners: bit 00H and bit 7FH
    do_op(2'b10, 2'd0, 3'd0, 8'h00, 1'b1, 8'h00, ~model[7'h20][0], 0);
    do_op(2'b10, 2'd0, 3'd0, 8'h7F, 1'b1, 8'h00, ~model[7'h2F][7], 0);
    do_op(2'b01, 2'd0, 3'd0, 8'h20, 1'b0, 8'h00, 1'b0, 0);
    do_op(2'b10, 2'd0, 3'd0, 8'h7F, 1'b0, 8'h00, 1'b0, 2);
    // R8: SFR side, direct and bit, read and write
    do_op(2'b01, 2'd0, 3'd0, 8'h80, 1'b0, 8'h00, 1'b0, 0);
    do_op(2'b01, 2'd0, 3'd0, 8'h90, 1'b1, 8'h77, 1'b0, 0);
    do_op(2'b10, 2'd0, 3'd0, 8'h83, 1'b1, 8'h00, ~model[7'h20][3], 0);
    do_op(2'b10, 2'd0, 3'd0, 8'hFF, 1'b0, 8'h00, 1'b0, 3);
    do_op(2'b01, 2'd0, 3'd0, 8'h10, 1'b0, 8'h00, 1'b0, 0);
    do_op(2'b01, 2'd0, 3'd0, 8'h20, 1'b0, 8'h00, 1'b0, 0);
    // R9: long hold on a scratch byte
    do_op(2'b01, 2'd0, 3'd0, 8'h55, 1'b0, 8'h00, 1'b0, 4);

    for (int n = 0; n < 400; n++) begin
      do_op(2'($urandom_range(0, 2)), 2'($urandom), 3'($urandom), 8'($urandom),
            1'($urandom), 8'($urandom), 1'($urandom), $urandom_range(0, 2));
    end

    sweep("R3 R7 R8 final image");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule